// File: doc/BRIEF.md
# Crossbar Intermediate Port Selector

This block schedules cell storage for a switch whose buffering is spread over the local memories of its N ports, with a crossbar between them. Every port memory can take in at most S1 cells from the crossbar in one time slot (write speedup) and can send at most S2 cells out in one slot (read speedup). For each arriving cell the scheduler must choose a storage port with spare write capacity in the current slot and spare read capacity in the slot the cell is due to leave. Cells are presented one per cycle, in sequence, together with a departure slot that some other central logic has already worked out.

The departure slot is given as an offset from the current slot, between 1 and D-1. Write usage is counted per port for the current slot only. Read usage is kept per port and per future slot in a circular table of D entries. The lowest-numbered port that meets both budgets wins, and both of its counters are bumped in the same cycle. If no port qualifies, the block reports a stall and leaves all state alone. A slot pulse moves the current slot on by one. The read counts of the current slot are shown at the ports as the read schedule the crossbar must carry out in that slot.

With S1 = S2 = 2 the write-free set and the read-free set always overlap for a legal request, so a stall then means the request itself broke the traffic rules.

Top module: `xbar_port_sel`

## Requirements
- R1: During reset and after it, grant_valid and stall are 0, all counters are 0, the current slot is 0, and rd_load is 0.
- R2: A request with offset 1..D-1 is answered one cycle later with grant_valid=1 and grant_port equal to the lowest-index port whose write count in the current slot is below S1 and whose read count in the target slot ((current + offset) mod D) is below S2.
- R3: No port is granted more than S1 times within one slot. With N=4 and S1=2, requests in one slot go to ports 0,0,1,1,2,2,3,3 when reads are free, and the ninth stalls.
- R4: No port is granted more than S2 times for the same departure slot. Once all ports have S2 reads in a target slot, a request for that slot stalls.
- R5: When no port qualifies, stall is 1 for one cycle, grant_valid is 0, and no write or read count changes.
- R6: A request with offset 0 is rejected with stall=1 and changes no counter.
- R7: A slot_tick pulse advances the current slot modulo D, clears all write counts and clears the read entry of the slot being left. rd_load shows the current slot's read counts, port p in bits [p*CW +: CW] (CW = 2 by default).
- R8: When slot_tick and a request arrive in the same cycle, the request is judged against the new slot: write counts are cleared and the target is the new current slot plus the offset.
- R9: grant_valid and stall are never both 1, and neither is 1 in a cycle after which no request was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | Pulse that starts the next time slot |
| req_valid | input | 1 | A cell needs a storage port this cycle |
| req_ofs | input | SLOT_BITS (3) | Departure slot as an offset from the current slot |
| grant_valid | output | 1 | Storage port chosen for the last request |
| grant_port | output | PW (2) | Index of the chosen storage port |
| stall | output | 1 | Last request could not be placed |
| rd_load | output | N*CW (8) | Read counts of every port for the current slot |

## Verification
The assertions watch, on every cycle, that no write or read counter goes past its budget, that a stall leaves the counters untouched, that an offset of 0 is always refused, that the picked port is the lowest eligible one, and that grant and stall stay exclusive and quiet when nothing was asked. What they cannot show is that the right counters were charged and cleared across slots: the filling order over one slot, exhaustion of a single departure slot, a request that coincides with a slot pulse, clearing of a slot once it has passed, and wrap of the circular table all depend on whole request sequences. Those are shown only by the bench scenarios, through grant_port and rd_load.

// File: rtl/xsel_pkg.sv
package xsel_pkg;

    // Bits needed to hold a count from 0 up to and including max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/xsel_avail.sv
module xsel_avail #(
    parameter int N  = 4,
    parameter int S1 = 2,
    parameter int S2 = 2,
    parameter int CW = 2
) (
    input  logic [N-1:0][CW-1:0] wr_cnt,
    input  logic [N-1:0][CW-1:0] rd_cnt,
    output logic [N-1:0]         elig
);
    localparam logic [CW-1:0] WR_LIM = CW'(S1);
    localparam logic [CW-1:0] RD_LIM = CW'(S2);

    // One comparator pair per port: write room now and read room at departure.
    for (genvar p = 0; p < N; p++) begin : g_port
        assign elig[p] = (wr_cnt[p] < WR_LIM) && (rd_cnt[p] < RD_LIM);
    end
endmodule

// File: rtl/xsel_pick.sv
module xsel_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  elig,
    output logic          found,
    output logic [PW-1:0] idx
);
    // Lowest index wins: walk from the top so the last hit is the smallest.
    always_comb begin
        found = |elig;
        idx   = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (elig[p]) idx = PW'(p);
        end
    end
endmodule

// File: rtl/xbar_port_sel.sv
module xbar_port_sel #(
    parameter int N         = 4,
    parameter int S1        = 2,
    parameter int S2        = 2,
    parameter int SLOT_BITS = 3,
    localparam int D        = 1 << SLOT_BITS,
    localparam int PW       = (N > 1) ? $clog2(N) : 1,
    localparam int CW       = xsel_pkg::cnt_width((S1 > S2) ? S1 : S2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_tick,
    input  logic                 req_valid,
    input  logic [SLOT_BITS-1:0] req_ofs,
    output logic                 grant_valid,
    output logic [PW-1:0]        grant_port,
    output logic                 stall,
    output logic [N*CW-1:0]      rd_load
);
    typedef logic [N-1:0][CW-1:0] port_cnt_t;

    typedef struct packed {
        port_cnt_t                  wr;
        logic [D-1:0][N-1:0][CW-1:0] rd;
        logic [SLOT_BITS-1:0]       cur;
        logic                       gv;
        logic [PW-1:0]              port;
        logic                       stall;
    } state_t;

    state_t st_q, st_d;

    // State as seen after an optional slot advance in this cycle.
    port_cnt_t                    wr_pre;
    logic [D-1:0][N-1:0][CW-1:0]  rd_pre;
    logic [SLOT_BITS-1:0]         cur_pre;
    logic [SLOT_BITS-1:0]         tgt_slot;
    port_cnt_t                    rd_at_tgt;
    logic [N-1:0]                 elig;
    logic                         pick_found;
    logic [PW-1:0]                pick_idx;

    always_comb begin
        wr_pre  = st_q.wr;
        rd_pre  = st_q.rd;
        cur_pre = st_q.cur;
        if (slot_tick) begin
            wr_pre          = '0;
            rd_pre[st_q.cur] = '0;
            cur_pre         = st_q.cur + SLOT_BITS'(1);
        end
        tgt_slot  = cur_pre + req_ofs;
        rd_at_tgt = rd_pre[tgt_slot];
    end

    xsel_avail #(.N(N), .S1(S1), .S2(S2), .CW(CW)) u_avail (
        .wr_cnt (wr_pre),
        .rd_cnt (rd_at_tgt),
        .elig   (elig)
    );

    xsel_pick #(.N(N), .PW(PW)) u_pick (
        .elig  (elig),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr    = wr_pre;
        st_d.rd    = rd_pre;
        st_d.cur   = cur_pre;
        st_d.gv    = 1'b0;
        st_d.stall = 1'b0;
        if (req_valid) begin
            if (req_ofs == '0 || !pick_found) begin
                st_d.stall = 1'b1;
            end else begin
                st_d.gv                     = 1'b1;
                st_d.port                   = pick_idx;
                st_d.wr[pick_idx]           = wr_pre[pick_idx] + CW'(1);
                st_d.rd[tgt_slot][pick_idx] = rd_pre[tgt_slot][pick_idx] + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_valid = st_q.gv;
    assign grant_port  = st_q.port;
    assign stall       = st_q.stall;
    assign rd_load     = st_q.rd[st_q.cur];

    // ---------------- assertions ----------------
    localparam logic [CW-1:0] WR_MAX = CW'(S1);
    localparam logic [CW-1:0] RD_MAX = CW'(S2);

    for (genvar p = 0; p < N; p++) begin : g_chk_port
        p_wr_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.wr[p] <= WR_MAX);
        for (genvar s = 0; s < D; s++) begin : g_chk_slot
            p_rd_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.rd[s][p] <= RD_MAX);
        end
    end

    p_pick_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pick_found |-> (elig[pick_idx] &&
                        ((elig & ~({N{1'b1}} << pick_idx)) == '0)));

    p_stall_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_tick && req_valid) |=> (stall |-> (st_q.wr == $past(st_q.wr) &&
                                                  st_q.rd == $past(st_q.rd))));

    p_zero_ofs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ofs == '0) |=> (stall && !grant_valid));

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && stall));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant_valid && !stall));

    p_tick_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && !req_valid) |=> (st_q.wr == '0));
endmodule

// File: tb/test_xbar_port_sel.sv
`timescale 1ns/1ps
module test_xbar_port_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_tick = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_ofs = '0;
    logic       grant_valid;
    logic [1:0] grant_port;
    logic       stall;
    logic [7:0] rd_load;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xbar_port_sel i_xbar_port_sel (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
        .req_valid(req_valid), .req_ofs(req_ofs),
        .grant_valid(grant_valid), .grant_port(grant_port),
        .stall(stall), .rd_load(rd_load)
    );

    typedef struct packed {
        logic       tick;
        logic       vld;
        logic [2:0] ofs;
        logic       egv;
        logic [1:0] eport;
        logic       est;
        logic [7:0] eload;
    } vec_t;

    // rd_load packs port p in bits [2p+1:2p].
    localparam vec_t VECS [20] = '{
        '{1'b0, 1'b1, 3'd1, 1'b1, 2'd0, 1'b0, 8'h00},  // R2 empty state -> port 0
        '{1'b0, 1'b1, 3'd1, 1'b1, 2'd0, 1'b0, 8'h00},  // R3 port 0 second write
        '{1'b0, 1'b1, 3'd1, 1'b1, 2'd1, 1'b0, 8'h00},  // R3 port 0 write-full
        '{1'b0, 1'b1, 3'd2, 1'b1, 2'd1, 1'b0, 8'h00},
        '{1'b0, 1'b1, 3'd2, 1'b1, 2'd2, 1'b0, 8'h00},
        '{1'b0, 1'b1, 3'd0, 1'b0, 2'd0, 1'b1, 8'h00},  // R6 zero offset refused
        '{1'b0, 1'b1, 3'd3, 1'b1, 2'd2, 1'b0, 8'h00},
        '{1'b0, 1'b1, 3'd3, 1'b1, 2'd3, 1'b0, 8'h00},
        '{1'b0, 1'b1, 3'd3, 1'b1, 2'd3, 1'b0, 8'h00},
        '{1'b0, 1'b1, 3'd4, 1'b0, 2'd0, 1'b1, 8'h00},  // R3 R5 ninth write stalls
        '{1'b1, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 8'h06},  // R7 R9 tick, slot 1 loads
        '{1'b0, 1'b1, 3'd1, 1'b1, 2'd0, 1'b0, 8'h06},  // R7 write counts cleared
        '{1'b0, 1'b1, 3'd1, 1'b1, 2'd0, 1'b0, 8'h06},
        '{1'b0, 1'b1, 3'd1, 1'b1, 2'd1, 1'b0, 8'h06},  // R4 port 1 already has one
        '{1'b0, 1'b1, 3'd1, 1'b1, 2'd2, 1'b0, 8'h06},
        '{1'b0, 1'b1, 3'd1, 1'b1, 2'd3, 1'b0, 8'h06},
        '{1'b0, 1'b1, 3'd1, 1'b1, 2'd3, 1'b0, 8'h06},
        '{1'b0, 1'b1, 3'd1, 1'b0, 2'd0, 1'b1, 8'h06},  // R4 R5 slot 2 read-full
        '{1'b0, 1'b1, 3'd2, 1'b1, 2'd1, 1'b0, 8'h06},  // R5 stall changed nothing
        '{1'b1, 1'b1, 3'd1, 1'b1, 2'd0, 1'b0, 8'hAA}   // R8 tick with request
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step(input logic tk, input logic vd, input logic [2:0] of);
        @(negedge clk);
        slot_tick = tk;
        req_valid = vd;
        req_ofs   = of;
        @(posedge clk);
        #1;
        @(negedge clk);
        slot_tick = 1'b0;
        req_valid = 1'b0;
        req_ofs   = '0;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(grant_valid == 1'b0 && stall == 1'b0, "R1 outputs in reset", {grant_valid, stall}, 0);
        check(rd_load == 8'h00, "R1 load in reset", rd_load, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            slot_tick = VECS[k].tick;
            req_valid = VECS[k].vld;
            req_ofs   = VECS[k].ofs;
            @(posedge clk);
            #1;
            check(grant_valid == VECS[k].egv, $sformatf("R2 R5 vec%0d grant_valid", k),
                  grant_valid, VECS[k].egv);
            if (VECS[k].egv)
                check(grant_port == VECS[k].eport, $sformatf("R2 vec%0d grant_port", k),
                      grant_port, VECS[k].eport);
            check(stall == VECS[k].est, $sformatf("R5 R9 vec%0d stall", k), stall, VECS[k].est);
            check(rd_load == VECS[k].eload, $sformatf("R7 vec%0d rd_load", k), rd_load, VECS[k].eload);
        end
        @(negedge clk);
        slot_tick = 1'b0;
        req_valid = 1'b0;
        req_ofs   = '0;

        // R7: slot 3 holds reads for ports 0,1,2 once each and port 3 twice.
        step(1'b1, 1'b0, 3'd0);
        check(rd_load == 8'h95, "R7 slot 3 load", rd_load, 8'h95);
        check(!grant_valid && !stall, "R9 idle tick quiet", {grant_valid, stall}, 0);
        for (int t = 0; t < 5; t++) step(1'b1, 1'b0, 3'd0);
        check(rd_load == 8'h00, "R7 wrapped to slot 0", rd_load, 0);
        step(1'b1, 1'b0, 3'd0);
        check(rd_load == 8'h00, "R7 passed slot 1 cleared", rd_load, 0);

        // R2 boundary: largest offset wraps to slot 0.
        step(1'b0, 1'b1, 3'd7);
        check(grant_valid && grant_port == 2'd0, "R2 max offset grant", grant_port, 0);
        for (int t = 0; t < 7; t++) step(1'b1, 1'b0, 3'd0);
        check(rd_load == 8'h01, "R7 wrapped entry load", rd_load, 8'h01);

        // R1: reset in the middle of traffic.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(!grant_valid && !stall, "R1 outputs after reset", {grant_valid, stall}, 0);
        check(rd_load == 8'h00, "R1 load after reset", rd_load, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 3'd1);
        check(grant_valid && grant_port == 2'd0, "R1 R2 first grant after reset", grant_port, 0);
        step(1'b1, 1'b0, 3'd0);
        check(rd_load == 8'h01, "R1 slot counter restarted", rd_load, 8'h01);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule